// File: doc/BRIEF.md
# Word-Framed Strobe Serializer

This block takes a parallel word, latched when a strobe rises, and sends it out on one data line with a clock line that travels alongside it. Every word goes out as a fixed frame of 26 slots. The first 24 slots are payload: the 22 data bits, least significant first, followed by two padding slots that are always zero. The last two slots mark the end of the word. In these two slots the clock line stays high while the data line goes 1 and then 0. A receiver can therefore find word edges from the line pattern alone, with no extra framing wire.

Slots advance on a bit enable that comes from the reference timebase. A two-bit rate select chooses powered-down, full rate, or half rate; half rate emits one slot for every second enable. When no word is waiting, the line carries zero filler while the clock keeps toggling. A word that is strobed while a frame is being sent waits in a single holding register. It follows the current frame directly, with no filler slot in between.

Top module: `strobe_word_serializer`

## Requirements
- R1: `par_word` is captured only on a rising edge of `strobe`, meaning `strobe` is sampled high at a clock edge after being sampled low at the previous one. A strobe that stays high captures nothing more.
- R2: In frame slot k, for k = 0 to 21, `ser_data` carries `par_word[k]` of the captured word.
- R3: Frame slots 22 and 23 always carry 0.
- R4: Frame slot 24 carries 1 and slot 25 carries 0. `ser_clk` is 1 in both slots.
- R5: In every payload or filler slot, `ser_clk` is the inverse of its value in the previous slot. A change of `ser_data` while `ser_clk` stays high is seen only on entry to slot 24 or slot 25.
- R6: When no word is held at the end of a frame, or while the line is idle, each slot carries `ser_data` = 0.
- R7: A word captured while a frame is being sent goes out in the slot right after slot 25 of that frame. With the enable high on every cycle, two such frames end exactly 26 cycles apart.
- R8: With `rate_sel` = 2'b11, a slot is emitted on every second `bit_en` pulse, counted from entry into that setting. With `rate_sel` = 2'b01 or 2'b10, a slot is emitted on every `bit_en` pulse.
- R9: While `rst` is high or `rate_sel` = 2'b00, both outputs are driven to 0, any frame in progress and any held word are discarded, and strobe edges are ignored.
- R10: Outputs change only at a clock edge where a slot is emitted. In cycles without a slot they keep their values.
- R11: `busy` is 1 exactly while a frame is in progress or a word is held.
- R12: A second strobe edge that arrives while a word is already held replaces that word. Only the newest word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Slot enable from the reference timebase |
| strobe | input | 1 | Capture strobe; its rising edge latches the word |
| par_word | input | 22 | Parallel word to send |
| rate_sel | input | 2 | 00 powered down, 01/10 full rate, 11 half rate |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Forwarded bit clock, edge-aligned with the data |
| busy | output | 1 | A frame is in progress or a word is held |

## Verification
A strobe sampled high at edge c puts the word in the holding register after edge c. Slot 0 of that word appears after the first slot-emitting edge that comes strictly later than c. Each slot value then stays on the outputs until the next emitting edge, and `busy` follows the same edges. The bench keeps a behavioural model that it advances at each rising edge from the same inputs. It compares the outputs at the following falling edge, half a cycle after they settle. It also decodes frames on its own from the line pattern, and checks gap lengths counted in clock cycles, to confirm back-to-back timing and half-rate timing.

// File: rtl/swser_pkg.sv
package swser_pkg;
  parameter int unsigned WORD_BITS     = 22;
  parameter int unsigned PAYLOAD_SLOTS = 24;
  parameter int unsigned MARK_SLOTS    = 2;

  typedef enum logic [1:0] {
    RATE_OFF    = 2'b00,
    RATE_FULL_A = 2'b01,
    RATE_FULL_B = 2'b10,
    RATE_HALF   = 2'b11
  } rate_sel_e;

  function automatic logic rate_is_off(input logic [1:0] sel);
    return sel == RATE_OFF;
  endfunction

  function automatic logic rate_is_half(input logic [1:0] sel);
    return sel == RATE_HALF;
  endfunction

  function automatic int unsigned frame_len(input int unsigned pay, input int unsigned mark);
    return pay + mark;
  endfunction
endpackage

// File: rtl/swser_rate_gen.sv
module swser_rate_gen
  import swser_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic       bit_en,
  output logic       slot_tick
);
  logic half_ph;
  logic half_mode;
  logic off_mode;

  assign half_mode = rate_is_half(rate_sel);
  assign off_mode  = rate_is_off(rate_sel);
  assign slot_tick = bit_en && !off_mode && (!half_mode || half_ph);

  always_ff @(posedge clk) begin
    if (rst || !half_mode) half_ph <= 1'b0;
    else if (bit_en)       half_ph <= ~half_ph;
  end

  assert_half_spacing_R8: assert property (@(posedge clk) disable iff (rst)
    (half_mode && slot_tick) |=> (!slot_tick || !half_mode));
endmodule

// File: rtl/swser_capture.sv
module swser_capture #(
  parameter int unsigned W = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         off,
  input  logic         strobe_i,
  input  logic [W-1:0] word_i,
  input  logic         take_i,
  output logic         hold_valid_o,
  output logic [W-1:0] hold_word_o,
  output logic         rise_o
);
  logic strobe_q;

  assign rise_o = strobe_i && !strobe_q;

  always_ff @(posedge clk) begin
    strobe_q <= rst ? 1'b0 : strobe_i;
    if (rst || off) begin
      hold_valid_o <= 1'b0;
      hold_word_o  <= '0;
    end else begin
      if (take_i) hold_valid_o <= 1'b0;
      if (rise_o) begin
        hold_valid_o <= 1'b1;
        hold_word_o  <= word_i;
      end
    end
  end

  // newest edge always wins the holding register (R12)
  assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
    (rise_o && !off) |=> (hold_valid_o && hold_word_o == $past(word_i)));
endmodule

// File: rtl/swser_framer.sv
module swser_framer
  import swser_pkg::*;
#(
  parameter int unsigned W    = 22,
  parameter int unsigned PAY  = 24,
  parameter int unsigned MARK = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         off,
  input  logic         tick,
  input  logic         hold_valid,
  input  logic [W-1:0] hold_word,
  output logic         take,
  output logic         ser_data,
  output logic         ser_clk,
  output logic         active,
  output logic         boundary
);
  localparam int unsigned FRAME = frame_len(PAY, MARK);
  localparam int unsigned SW    = $clog2(FRAME);
  localparam logic [SW-1:0] LAST   = SW'(FRAME - 1);
  localparam logic [SW-1:0] PAYIDX = SW'(PAY);
  localparam logic [SW-1:0] PADIDX = SW'(W);

  logic [SW-1:0]  slot;
  logic [SW-1:0]  nxt;
  logic [PAY-1:0] shreg;
  logic           frame_last;

  assign frame_last = active && (slot == LAST);
  assign take       = tick && hold_valid && (!active || frame_last);
  assign nxt        = slot + 1'b1;
  assign boundary   = active && (slot >= PAYIDX);

  always_ff @(posedge clk) begin
    if (rst || off) begin
      active   <= 1'b0;
      slot     <= '0;
      shreg    <= '0;
      ser_data <= 1'b0;
      ser_clk  <= 1'b0;
    end else if (tick) begin
      if (take) begin
        active   <= 1'b1;
        slot     <= '0;
        shreg    <= PAY'(hold_word) >> 1;
        ser_data <= hold_word[0];
        ser_clk  <= ~ser_clk;
      end else if (active && !frame_last) begin
        slot <= nxt;
        if (nxt < PAYIDX) begin
          ser_data <= shreg[0];
          shreg    <= shreg >> 1;
          ser_clk  <= ~ser_clk;
        end else begin
          ser_data <= (nxt == PAYIDX);
          ser_clk  <= 1'b1;
        end
      end else begin
        active   <= 1'b0;
        slot     <= '0;
        ser_data <= 1'b0;
        ser_clk  <= ~ser_clk;
      end
    end
  end

  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (active && slot >= PADIDX && slot < PAYIDX) |-> !ser_data);
  assert_mark_clk_high_R4: assert property (@(posedge clk) disable iff (rst)
    boundary |-> ser_clk);
  assert_static_clk_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && $past(ser_clk) && (ser_data != $past(ser_data))) |-> boundary);
  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    off |=> (!ser_data && !ser_clk && !active));
  assert_hold_between_slots_R10: assert property (@(posedge clk) disable iff (rst)
    (!tick && !off) |=> ($stable(ser_data) && $stable(ser_clk)));
endmodule

// File: rtl/strobe_word_serializer.sv
module strobe_word_serializer
  import swser_pkg::*;
#(
  parameter int unsigned WORD_W    = WORD_BITS,
  parameter int unsigned PAY_SLOTS = PAYLOAD_SLOTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              strobe,
  input  logic [WORD_W-1:0] par_word,
  input  logic [1:0]        rate_sel,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              busy
);
  logic              off;
  logic              slot_tick;
  logic              take;
  logic              hold_valid;
  logic [WORD_W-1:0] hold_word;
  logic              strobe_rise;
  logic              active;
  logic              boundary;

  assign off  = rate_is_off(rate_sel);
  assign busy = active || hold_valid;

  swser_rate_gen u_rate (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .bit_en(bit_en), .slot_tick(slot_tick)
  );

  swser_capture #(.W(WORD_W)) u_cap (
    .clk(clk), .rst(rst), .off(off), .strobe_i(strobe), .word_i(par_word),
    .take_i(take), .hold_valid_o(hold_valid), .hold_word_o(hold_word), .rise_o(strobe_rise)
  );

  swser_framer #(.W(WORD_W), .PAY(PAY_SLOTS), .MARK(MARK_SLOTS)) u_frm (
    .clk(clk), .rst(rst), .off(off), .tick(slot_tick), .hold_valid(hold_valid),
    .hold_word(hold_word), .take(take), .ser_data(ser_data), .ser_clk(ser_clk),
    .active(active), .boundary(boundary)
  );

  assert_no_take_when_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !strobe_rise) |=> !active);
  assert_busy_idle_off_R11: assert property (@(posedge clk) disable iff (rst)
    off |=> !busy);
endmodule

// File: tb/tb_strobe_word_serializer.sv
module tb_strobe_word_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        strobe = 1'b0;
  logic [21:0] par_word = '0;
  logic [1:0]  rate_sel = 2'b01;
  logic        ser_data, ser_clk, busy;

  always #5 clk = ~clk;

  strobe_word_serializer dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .strobe(strobe), .par_word(par_word),
    .rate_sel(rate_sel), .ser_data(ser_data), .ser_clk(ser_clk), .busy(busy)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // enable pattern: <0 never, 0 always, k every k-th cycle
  int en_pat = 0;
  int en_cnt = 0;
  always @(negedge clk) begin
    en_cnt++;
    if (en_pat < 0)       bit_en = 1'b0;
    else if (en_pat == 0) bit_en = 1'b1;
    else                  bit_en = (en_cnt % en_pat == 0);
  end

  // behavioural reference model
  int          cyc = 0;
  bit          m_ph, m_act, m_hv, m_sq, m_d, m_c, m_tick, m_quiet;
  int          m_slot;
  logic [21:0] m_hw, m_word;
  always @(posedge clk) begin
    cyc++;
    m_tick  = 0;
    m_quiet = rst || (rate_sel == 2'b00);
    if (m_quiet) begin
      m_ph = 0; m_act = 0; m_slot = 0; m_hv = 0; m_hw = '0; m_d = 0; m_c = 0;
      m_sq = rst ? 1'b0 : strobe;
    end else begin
      m_tick = bit_en && (rate_sel != 2'b11 || m_ph);
      if (rate_sel == 2'b11) begin
        if (bit_en) m_ph = !m_ph;
      end else m_ph = 0;
      if (m_tick) begin
        if (m_hv && (!m_act || m_slot == 25)) begin
          m_word = m_hw; m_hv = 0; m_act = 1; m_slot = 0;
          m_d = m_word[0]; m_c = !m_c;
        end else if (m_act && m_slot < 25) begin
          m_slot++;
          if (m_slot < 24) begin
            m_d = (m_slot < 22) ? m_word[m_slot] : 1'b0;
            m_c = !m_c;
          end else begin
            m_d = (m_slot == 24); m_c = 1;
          end
        end else begin
          m_act = 0; m_slot = 0; m_d = 0; m_c = !m_c;
        end
      end
      if (strobe && !m_sq) begin m_hv = 1; m_hw = par_word; end
      m_sq = strobe;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    string tag;
    if (m_quiet)                       tag = "R9";
    else if (m_act && m_slot >= 24)    tag = "R4";
    else if (m_act && m_slot >= 22)    tag = "R3";
    else if (m_act)                    tag = "R2";
    else                               tag = "R6";
    check(ser_data === m_d, {tag, " ser_data"}, ser_data, m_d);
    check(ser_clk === m_c, {tag, " ser_clk (R5)"}, ser_clk, m_c);
    check(busy === (m_act || m_hv), "R11 busy", busy, m_act || m_hv);
  end

  // independent line decoder
  logic [21:0] exp_q[$];
  logic [25:0] hd = '0;
  bit          pd = 0, pc = 0;
  int          nframes = 0, last_end = 0, last_gap = 0;
  always @(negedge clk) begin
    if (m_quiet) begin
      hd = '0; pd = 0; pc = 0;
    end else if (m_tick) begin
      hd = {hd[24:0], ser_data};
      if (ser_clk && pc && pd && !ser_data) begin
        logic [21:0] w;
        for (int k = 0; k < 22; k++) w[k] = hd[25-k];
        nframes++;
        last_gap = cyc - last_end;
        last_end = cyc;
        check(hd[3:2] == 2'b00, "R3 pad slots", hd[3:2], 0);
        if (exp_q.size() == 0) check(0, "R1 unexpected frame", w, 0);
        else begin
          logic [21:0] e;
          e = exp_q.pop_front();
          check(w == e, "R2 decoded word", w, e);
        end
      end
      pd = ser_data; pc = ser_clk;
    end
  end

  task automatic pulse(input logic [21:0] w, input int hi, input bit push);
    @(negedge clk);
    par_word = w; strobe = 1;
    repeat (hi) @(negedge clk);
    strobe = 0;
    if (push) exp_q.push_back(w);
  endtask

  task automatic drain();
    int g = 0;
    @(negedge clk);
    while (busy && g < 5000) begin @(negedge clk); g++; end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(ser_data == 0 && ser_clk == 0 && busy == 0, "R9 reset state",
          {ser_data, ser_clk, busy}, 0);
    rst = 0;
    repeat (30) @(negedge clk);
    check(ser_data == 0 && busy == 0, "R6 idle filler", ser_data, 0);

    pulse(22'h2A5A5F, 1, 1);
    drain();

    // back-to-back, second word held (R7)
    pulse(22'h3FFFFF, 1, 1);
    repeat (5) @(negedge clk);
    pulse(22'h000001, 1, 1);
    drain();
    check(last_gap == 26, "R7 back-to-back gap", last_gap, 26);

    // newest held word wins (R12)
    pulse(22'h155555, 1, 1);
    repeat (3) @(negedge clk);
    pulse(22'h0F0F0F, 1, 0);
    repeat (3) @(negedge clk);
    pulse(22'h123456, 1, 1);
    drain();
    check(exp_q.size() == 0, "R12 held word replaced", exp_q.size(), 0);

    // level-held strobe captures once (R1)
    @(negedge clk);
    par_word = 22'h0ABCDE; strobe = 1; exp_q.push_back(22'h0ABCDE);
    repeat (10) @(negedge clk);
    par_word = 22'h3C3C3C;
    repeat (60) @(negedge clk);
    strobe = 0;
    drain();
    check(exp_q.size() == 0, "R1 single capture", exp_q.size(), 0);

    // sparse enable
    en_pat = 3;
    pulse(22'h1E1E1E, 1, 1);
    repeat (20) @(negedge clk);
    pulse(22'h2D2D2D, 1, 1);
    drain();

    // half rate (R8)
    en_pat = 0; rate_sel = 2'b11;
    pulse(22'h33CC33, 1, 1);
    repeat (5) @(negedge clk);
    pulse(22'h0C3C3C, 1, 1);
    drain();
    check(last_gap == 52, "R8 half-rate gap", last_gap, 52);

    // other full-rate code
    rate_sel = 2'b10;
    pulse(22'h2468AC, 1, 1);
    drain();

    // no enable: outputs frozen (R10)
    pulse(22'h3579BD, 1, 1);
    repeat (9) @(negedge clk);
    en_pat = -1;
    repeat (2) @(negedge clk);
    begin
      logic sd, sc;
      sd = ser_data; sc = ser_clk;
      repeat (15) @(negedge clk);
      check(ser_data == sd && ser_clk == sc, "R10 frozen without enable",
            {ser_data, ser_clk}, {sd, sc});
    end
    en_pat = 0;
    drain();

    // power-down discards in-flight and held words (R9)
    begin
      int nf;
      pulse(22'h111111, 1, 0);
      repeat (5) @(negedge clk);
      pulse(22'h222222, 1, 0);
      repeat (3) @(negedge clk);
      rate_sel = 2'b00;
      @(negedge clk);
      check(ser_data == 0 && ser_clk == 0 && busy == 0, "R9 power-down quiet",
            {ser_data, ser_clk, busy}, 0);
      pulse(22'h333333, 1, 0);
      nf = nframes;
      rate_sel = 2'b01;
      repeat (80) @(negedge clk);
      check(nframes == nf && busy == 0, "R9 words discarded", nframes, nf);
    end

    check(exp_q.size() == 0, "R2 all words delivered", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule